// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a management-bus master for Clause 45 PHYs, placed behind a simple 32-bit register port. Software writes the target PHY port and MMD device numbers into a control word and then triggers one frame per register write. A write to the address word sends an address frame that sets the PHY's internal register pointer. A write to the data word sends a write frame. A control write with its read bit set sends a read frame, and the 16 bits the PHY returns are captured into the data word.

The block drives the management clock and the data line, with a separate output enable so that the line can be turned around during reads. The management clock is divided down from the system clock by a programmable field. Two busy flags can be polled. One covers any frame on the bus. The other covers only the read or write transaction. A read-error flag reports a PHY that did not answer.

Top module: `c45_mgmt_master`

## Requirements
- R1: Register words are byte offset 0x30 status/config, 0x34 control, 0x38 data and 0x3C address. Every other word reads as zero. After reset, status reads 0x00000100 (divider field = 1) and control, data and address read 0.
- R2: The status bits 15:8 hold the divider value D. While a frame runs, `mdc` toggles every 2*D+1 system clocks. While no frame runs, `mdc` is low.
- R3: A frame opens with 32 preamble bits of one, unless control bit 10 is set, in which case it begins directly with the start bits.
- R4: After the preamble a frame carries start 00, a 2-bit opcode, the 5-bit port (control bits 9:5), the 5-bit device (control bits 4:0), a 2-bit turnaround and 16 bits, MSB first. Writing the address word sends opcode 00 with its low 16 bits, and those bits read back from the address word.
- R5: Writing the data word sends opcode 01 with the turnaround driven as 10 and the low 16 bits as payload. Those bits read back in data bits 15:0.
- R6: Writing control with bit 15 set sends a read frame. The opcode is 11, or 10 when control bit 14 is also set. At the end of the frame the 16 received bits appear in data bits 15:0.
- R7: Data is driven only while `mdio_oe` is high and changes only while `mdc` is low. In a read frame `mdio_oe` is low from the first turnaround bit to the end, and it is low whenever no frame runs.
- R8: If the line is sampled high in the second turnaround bit of a read, status bit 1 is set at the end of the frame, and the data word then holds the bits sampled from the pulled-up line (0xFFFF). The next read start clears the flag.
- R9: Status bit 0 is high while any frame runs. Data bit 31 is high only during read and write frames.
- R10: Both busy flags drop exactly one system clock after the final falling edge of `mdc` in a frame.
- R11: While a frame runs, writes to any word are discarded: they store nothing and start nothing.
- R12: Control bit 11 is stored and reads back, and it has no effect on the bus. A control write without bit 15 starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in (line pulled high when nobody drives) |

## Verification
A corrupted bit position or shift state shows up on the pins within the same frame: a wrong opcode, port, device or payload is seen by the bench PHY as soon as the 32 frame bits have gone out. A wrong turnaround handling shows as the enable still high in the bit after the opcode's turnaround starts, or as a read-error flag that disagrees with whether the PHY answered. A wrong divider or frame-end state shows at the first `mdc` edges as a wrong period, or as a busy flag that falls some clocks away from the last falling clock edge. A wrong busy gate shows as register contents changed, or an extra frame, after writes issued mid-frame.

// File: rtl/c45_mgmt_pkg.sv
`timescale 1ns/1ps
package c45_mgmt_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned FIELD_W   = 16;
    localparam int unsigned ID_W      = 5;
    localparam int unsigned PRE_LEN   = 32;
    localparam int unsigned BODY_LEN  = 32;
    localparam int unsigned FRAME_LEN = PRE_LEN + BODY_LEN;
    localparam int unsigned HDR_LEN   = 14;

    localparam int unsigned STATUS_WORD = 12;
    localparam int unsigned CTRL_WORD   = 13;
    localparam int unsigned DATA_WORD   = 14;
    localparam int unsigned ADDR_WORD   = 15;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'b00,
        OP_WRITE = 2'b01,
        OP_RDINC = 2'b10,
        OP_READ  = 2'b11
    } mdio_op_e;

    typedef struct packed {
        logic [ID_W-1:0] dev;
        logic [ID_W-1:0] port;
        logic            no_pre;
        logic            scan;
        logic            post_inc;
    } ctl_fields_t;

    typedef struct packed {
        mdio_op_e           op;
        logic [ID_W-1:0]    port;
        logic [ID_W-1:0]    dev;
        logic [FIELD_W-1:0] payload;
        logic               skip_pre;
    } frame_req_t;

    typedef struct packed {
        logic               done;
        logic               rd;
        logic               err;
        logic [FIELD_W-1:0] rx;
    } frame_rsp_t;

    function automatic logic op_is_read(input mdio_op_e op);
        return op[1];
    endfunction

    function automatic logic [FRAME_LEN-1:0] pack_frame(input frame_req_t r);
        logic [BODY_LEN-1:0] body;
        logic [1:0]          ta;
        logic [FIELD_W-1:0]  pl;
        ta   = op_is_read(r.op) ? 2'b11 : 2'b10;
        pl   = op_is_read(r.op) ? {FIELD_W{1'b1}} : r.payload;
        body = {2'b00, r.op, r.port, r.dev, ta, pl};
        if (r.skip_pre)
            return {body, {PRE_LEN{1'b1}}};
        return {{PRE_LEN{1'b1}}, body};
    endfunction

endpackage

// File: rtl/c45_mdc_gen.sv
`timescale 1ns/1ps
module c45_mdc_gen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    localparam int unsigned CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             mdc_q;
    logic             tick;

    assign limit = {div, 1'b0};
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc  = mdc_q;
    assign rise = tick & ~mdc_q;
    assign fall = tick & mdc_q;
endmodule

// File: rtl/c45_frame_engine.sv
`timescale 1ns/1ps
module c45_frame_engine
    import c45_mgmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  frame_req_t req,
    input  logic       rise,
    input  logic       fall,
    input  logic       mdio_i,
    output logic       active,
    output logic       run,
    output logic       mdio_o,
    output logic       mdio_oe,
    output frame_rsp_t rsp
);
    localparam int unsigned POS_W = $clog2(FRAME_LEN);
    localparam logic [POS_W-1:0] P_BODY = POS_W'(PRE_LEN);
    localparam logic [POS_W-1:0] P_TA1  = POS_W'(PRE_LEN + HDR_LEN);
    localparam logic [POS_W-1:0] P_TA2  = POS_W'(PRE_LEN + HDR_LEN + 1);
    localparam logic [POS_W-1:0] P_DATA = POS_W'(PRE_LEN + HDR_LEN + 2);
    localparam logic [POS_W-1:0] P_LAST = POS_W'(FRAME_LEN - 1);

    logic                 active_q;
    logic                 fin_q;
    logic                 rd_q;
    logic                 err_q;
    logic [POS_W-1:0]     pos_q;
    logic [FRAME_LEN-1:0] sh_q;
    logic [FIELD_W-1:0]   rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            fin_q    <= 1'b0;
            rd_q     <= 1'b0;
            err_q    <= 1'b0;
            pos_q    <= '0;
            sh_q     <= '1;
            rx_q     <= '0;
        end else if (!active_q) begin
            if (req_valid) begin
                active_q <= 1'b1;
                fin_q    <= 1'b0;
                sh_q     <= pack_frame(req);
                pos_q    <= req.skip_pre ? P_BODY : '0;
                rd_q     <= op_is_read(req.op);
                err_q    <= 1'b0;
            end
        end else if (fin_q) begin
            active_q <= 1'b0;
            fin_q    <= 1'b0;
        end else begin
            if (fall) begin
                if (pos_q == P_LAST) begin
                    fin_q <= 1'b1;
                end else begin
                    pos_q <= pos_q + 1'b1;
                    sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b1};
                end
            end
            if (rise && rd_q) begin
                if (pos_q == P_TA2)
                    err_q <= mdio_i;
                if (pos_q >= P_DATA)
                    rx_q <= {rx_q[FIELD_W-2:0], mdio_i};
            end
        end
    end

    assign active  = active_q;
    assign run     = active_q & ~fin_q;
    assign mdio_o  = active_q ? sh_q[FRAME_LEN-1] : 1'b1;
    assign mdio_oe = active_q & ~(rd_q & (pos_q >= P_TA1));

    always_comb begin
        rsp.done = fin_q;
        rsp.rd   = rd_q;
        rsp.err  = err_q;
        rsp.rx   = rx_q;
    end
endmodule

// File: rtl/c45_reg_bank.sv
`timescale 1ns/1ps
module c45_reg_bank
    import c45_mgmt_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DIV_W   = 8,
    parameter logic [7:0]  RST_DIV = 8'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              bus_busy,
    input  frame_rsp_t        rsp,
    output logic              req_valid,
    output frame_req_t        req,
    output logic [DIV_W-1:0]  div,
    output logic              txn_busy
);
    localparam int unsigned WIX_W = ADDR_W - 2;
    localparam logic [WIX_W-1:0] W_STAT = WIX_W'(STATUS_WORD);
    localparam logic [WIX_W-1:0] W_CTRL = WIX_W'(CTRL_WORD);
    localparam logic [WIX_W-1:0] W_DATA = WIX_W'(DATA_WORD);
    localparam logic [WIX_W-1:0] W_ADDR = WIX_W'(ADDR_WORD);

    logic [WIX_W-1:0]   wix;
    logic               wr_ok;
    logic               hit_stat, hit_ctrl, hit_data, hit_addr;
    logic               rd_start;
    ctl_fields_t        ctl_q, ctl_new;
    logic [DIV_W-1:0]   div_q;
    logic [FIELD_W-1:0] data_q;
    logic [FIELD_W-1:0] addr_q;
    logic               txn_q;
    logic               err_q;
    logic               unused_bits;

    assign wix      = addr[ADDR_W-1:2];
    assign wr_ok    = we & ~bus_busy;
    assign hit_stat = wr_ok && (wix == W_STAT);
    assign hit_ctrl = wr_ok && (wix == W_CTRL);
    assign hit_data = wr_ok && (wix == W_DATA);
    assign hit_addr = wr_ok && (wix == W_ADDR);
    assign rd_start = hit_ctrl & wdata[15];

    always_comb begin
        ctl_new.dev      = wdata[4:0];
        ctl_new.port     = wdata[9:5];
        ctl_new.no_pre   = wdata[10];
        ctl_new.scan     = wdata[11];
        ctl_new.post_inc = wdata[14];
    end

    always_comb begin
        req_valid   = hit_addr | hit_data | rd_start;
        req.port    = hit_ctrl ? ctl_new.port   : ctl_q.port;
        req.dev     = hit_ctrl ? ctl_new.dev    : ctl_q.dev;
        req.skip_pre = hit_ctrl ? ctl_new.no_pre : ctl_q.no_pre;
        req.payload = wdata[FIELD_W-1:0];
        if (hit_addr)
            req.op = OP_ADDR;
        else if (hit_data)
            req.op = OP_WRITE;
        else if (ctl_new.post_inc)
            req.op = OP_RDINC;
        else
            req.op = OP_READ;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            div_q  <= DIV_W'(RST_DIV);
            data_q <= '0;
            addr_q <= '0;
            txn_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (hit_stat)
                div_q <= wdata[8 +: DIV_W];
            if (hit_ctrl)
                ctl_q <= ctl_new;
            if (hit_addr)
                addr_q <= wdata[FIELD_W-1:0];
            if (hit_data) begin
                data_q <= wdata[FIELD_W-1:0];
                txn_q  <= 1'b1;
            end
            if (rd_start) begin
                txn_q <= 1'b1;
                err_q <= 1'b0;
            end
            if (rsp.done) begin
                txn_q <= 1'b0;
                if (rsp.rd) begin
                    data_q <= rsp.rx;
                    err_q  <= rsp.err;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (wix)
            W_STAT: rdata = {16'h0, div_q, 6'h0, err_q, bus_busy};
            W_CTRL: rdata = {16'h0, 1'b0, ctl_q.post_inc, 2'b00, ctl_q.scan,
                             ctl_q.no_pre, ctl_q.port, ctl_q.dev};
            W_DATA: rdata = {txn_q, 15'h0, data_q};
            W_ADDR: rdata = {16'h0, addr_q};
            default: rdata = '0;
        endcase
    end

    assign unused_bits = ^{wdata[31:16], wdata[13:12], addr[1:0]};
    assign div         = div_q;
    assign txn_busy    = txn_q;
endmodule

// File: rtl/c45_mgmt_master.sv
`timescale 1ns/1ps
module c45_mgmt_master
    import c45_mgmt_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DIV_W   = 8,
    parameter logic [7:0]  RST_DIV = 8'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic             req_valid;
    frame_req_t       req;
    frame_rsp_t       rsp;
    logic             bus_busy;
    logic             txn_busy;
    logic             run;
    logic             rise;
    logic             fall;
    logic [DIV_W-1:0] div;

    c45_reg_bank #(
        .ADDR_W (ADDR_W),
        .DIV_W  (DIV_W),
        .RST_DIV(RST_DIV)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .bus_busy (bus_busy),
        .rsp      (rsp),
        .req_valid(req_valid),
        .req      (req),
        .div      (div),
        .txn_busy (txn_busy)
    );

    c45_mdc_gen #(.DIV_W(DIV_W)) u_clkgen (
        .clk (clk),
        .rst (rst),
        .run (run),
        .div (div),
        .mdc (mdc),
        .rise(rise),
        .fall(fall)
    );

    c45_frame_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req      (req),
        .rise     (rise),
        .fall     (fall),
        .mdio_i   (mdio_i),
        .active   (bus_busy),
        .run      (run),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rsp      (rsp)
    );
endmodule

// File: rtl/c45_mgmt_checker.sv
`timescale 1ns/1ps
module c45_mgmt_checker #(
    parameter int unsigned DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             bus_busy,
    input logic             txn_busy,
    input logic [DIV_W-1:0] div
);
    AST_TXN_WITHIN_BUS: assert property (@(posedge clk) disable iff (rst)
        txn_busy |-> bus_busy); // R9

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !bus_busy |-> !mdc); // R2

    AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !bus_busy |-> !mdio_oe); // R7

    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R7

    AST_BUSY_TAIL: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_busy) |-> $past($fell(mdc))); // R10

    AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (bus_busy && $past(bus_busy)) |-> $stable(div)); // R11
endmodule

bind c45_mgmt_master c45_mgmt_checker #(.DIV_W(DIV_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .bus_busy(bus_busy),
    .txn_busy(txn_busy),
    .div     (div)
);

// File: tb/sim_c45_mgmt_master.sv
`timescale 1ns/1ps
module sim_c45_mgmt_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;
    logic        phy_here = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int n_push = 0;
    int n_seen = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    c45_mgmt_master u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    typedef struct {
        logic [1:0]  op;
        logic [4:0]  port;
        logic [4:0]  dev;
        logic [15:0] payload;
        logic        pre;
    } exp_t;
    exp_t sb_q[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] d);
        return {p, d, 1'b0, p ^ d};
    endfunction

    function automatic logic [31:0] ctlw(input logic [4:0] p, input logic [4:0] d,
                                         input bit nopre, input bit inc, input bit scan, input bit rd);
        return {16'h0, rd, inc, 2'b00, scan, nopre, p, d};
    endfunction

    task automatic push(input logic [1:0] op, input logic [4:0] p, input logic [4:0] d,
                        input logic [15:0] pl, input bit pre);
        exp_t e;
        e.op = op; e.port = p; e.dev = d; e.payload = pl; e.pre = pre;
        sb_q.push_back(e);
        n_push++;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    realtime t_fall = 0;
    always @(negedge mdc) t_fall = $realtime;

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            bus_rd(8'h30, v);
            if (!v[0]) begin
                chk(($realtime - 1.0 - t_fall) == 12.0, "R10 busy end vs last mdc fall (ns)",
                    32'($rtoi($realtime - 1.0 - t_fall)), 32'd12);
                return;
            end
        end
        chk(1'b0, "R9 busy never cleared", 32'd1, 32'd0);
    endtask

    // bench PHY: decodes frames from the pins and answers reads
    int          mon_k = -1;
    int          pre_ones = 0;
    int          pre_seen = 0;
    logic [13:0] hdr;
    logic [15:0] dat;
    logic [15:0] rd_val;
    bit          oe_bad;

    always @(posedge mdc) begin
        if (mon_k < 0) begin
            if (mdio_oe && mdio_o) pre_ones++;
            else if (mdio_oe && !mdio_o) begin
                mon_k = 1; hdr = '0; dat = '0; oe_bad = 1'b0; pre_seen = pre_ones;
            end
        end else begin
            if (mon_k < 14) begin
                hdr[13-mon_k] = mdio_o;
                if (!mdio_oe) oe_bad = 1'b1;
                if (mon_k == 13) rd_val = phy_val(hdr[9:5], hdr[4:0]);
            end else if (hdr[11]) begin
                if (mdio_oe) oe_bad = 1'b1;
                if (mon_k >= 16) dat[31-mon_k] = mdio_i;
            end else begin
                if (!mdio_oe) oe_bad = 1'b1;
                if (mon_k >= 16) dat[31-mon_k] = mdio_o;
            end
            if (mon_k == 31) begin
                exp_t e;
                n_seen++;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected frame", 32'(hdr), 32'h0);
                end else begin
                    e = sb_q.pop_front();
                    chk(hdr[13:12] == 2'b00, "R4 start bits", 32'(hdr[13:12]), 32'h0);
                    chk(hdr[11:10] == e.op, "R4 opcode", 32'(hdr[11:10]), 32'(e.op));
                    chk(hdr[9:5] == e.port, "R4 port", 32'(hdr[9:5]), 32'(e.port));
                    chk(hdr[4:0] == e.dev, "R4 device", 32'(hdr[4:0]), 32'(e.dev));
                    chk(pre_seen == (e.pre ? 32 : 0), "R3 preamble length", 32'(pre_seen), e.pre ? 32'd32 : 32'd0);
                    chk(!oe_bad, "R7 output enable per bit", 32'(oe_bad), 32'h0);
                    if (!e.op[1])
                        chk(dat == e.payload, "R5 payload bits", 32'(dat), 32'(e.payload));
                end
                mon_k = -1;
                pre_ones = 0;
            end else begin
                mon_k++;
            end
        end
    end

    always @(negedge mdc) begin
        if (mon_k >= 15 && hdr[11] && phy_here)
            mdio_i = (mon_k == 15) ? 1'b0 : rd_val[31-mon_k];
        else
            mdio_i = 1'b1;
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        realtime t0, t1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        bus_rd(8'h30, v); chk(v == 32'h0000_0100, "R1 status reset", v, 32'h0000_0100);
        bus_rd(8'h34, v); chk(v == 32'h0, "R1 control reset", v, 32'h0);
        bus_rd(8'h38, v); chk(v == 32'h0, "R1 data reset", v, 32'h0);
        bus_rd(8'h3C, v); chk(v == 32'h0, "R1 address reset", v, 32'h0);
        bus_rd(8'h00, v); chk(v == 32'h0, "R1 reserved word 0", v, 32'h0);
        bus_rd(8'h2C, v); chk(v == 32'h0, "R1 reserved word 11", v, 32'h0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R2 idle mdc low", {30'h0, mdc, mdio_oe}, 32'h0);

        // address frame
        bus_wr(8'h34, ctlw(5'd3, 5'd1, 0, 0, 0, 0));
        bus_rd(8'h30, v); chk(v[0] == 1'b0, "R12 control write starts nothing", v, 32'h0000_0100);
        push(2'b00, 5'd3, 5'd1, 16'hA5C3, 1'b1);
        bus_wr(8'h3C, 32'hFFFF_A5C3);
        bus_rd(8'h30, v); chk(v[0] == 1'b1, "R9 bus busy on address frame", v, 32'h0000_0101);
        bus_rd(8'h38, v); chk(v[31] == 1'b0, "R9 no transaction busy on address frame", v, 32'h0);
        wait_idle();
        bus_rd(8'h3C, v); chk(v == 32'h0000_A5C3, "R4 address readback", v, 32'h0000_A5C3);

        // write frame
        push(2'b01, 5'd3, 5'd1, 16'h1234, 1'b1);
        bus_wr(8'h38, 32'h0000_1234);
        bus_rd(8'h38, v); chk(v[31] == 1'b1, "R9 transaction busy on write", v, 32'h8000_1234);
        wait_idle();
        bus_rd(8'h38, v); chk(v == 32'h0000_1234, "R5 data readback", v, 32'h0000_1234);

        // read frame
        push(2'b11, 5'd7, 5'd2, 16'h0, 1'b1);
        bus_wr(8'h34, ctlw(5'd7, 5'd2, 0, 0, 0, 1));
        bus_rd(8'h38, v); chk(v[31] == 1'b1, "R9 transaction busy on read", v, 32'h8000_0000);
        wait_idle();
        bus_rd(8'h38, v); chk(v == {16'h0, phy_val(5'd7, 5'd2)}, "R6 read value", v, {16'h0, phy_val(5'd7, 5'd2)});
        bus_rd(8'h30, v); chk(v[1] == 1'b0, "R8 no error with PHY present", v, 32'h0000_0100);

        // post-increment read
        push(2'b10, 5'd30, 5'd17, 16'h0, 1'b1);
        bus_wr(8'h34, ctlw(5'd30, 5'd17, 0, 1, 0, 1));
        wait_idle();
        bus_rd(8'h38, v); chk(v == {16'h0, phy_val(5'd30, 5'd17)}, "R6 post-increment read value", v, {16'h0, phy_val(5'd30, 5'd17)});
        bus_rd(8'h34, v); chk(v == ctlw(5'd30, 5'd17, 0, 1, 0, 0), "R6 control readback", v, ctlw(5'd30, 5'd17, 0, 1, 0, 0));

        // preamble suppressed write
        bus_wr(8'h34, ctlw(5'd9, 5'd4, 1, 0, 0, 0));
        bus_rd(8'h34, v); chk(v[10] == 1'b1, "R3 preamble-disable stored", v, ctlw(5'd9, 5'd4, 1, 0, 0, 0));
        push(2'b01, 5'd9, 5'd4, 16'hBEEF, 1'b0);
        bus_wr(8'h38, 32'h0000_BEEF);
        wait_idle();

        // absent PHY read
        phy_here = 1'b0;
        push(2'b11, 5'd12, 5'd5, 16'h0, 1'b1);
        bus_wr(8'h34, ctlw(5'd12, 5'd5, 0, 0, 0, 1));
        wait_idle();
        bus_rd(8'h30, v); chk(v[1] == 1'b1, "R8 read error flag", v, 32'h0000_0102);
        bus_rd(8'h38, v); chk(v == 32'h0000_FFFF, "R8 pulled-up data", v, 32'h0000_FFFF);
        phy_here = 1'b1;
        push(2'b11, 5'd12, 5'd5, 16'h0, 1'b1);
        bus_wr(8'h34, ctlw(5'd12, 5'd5, 0, 0, 0, 1));
        bus_rd(8'h30, v); chk(v[1] == 1'b0, "R8 error cleared at read start", v, 32'h0000_0101);
        wait_idle();

        // writes during a frame are discarded
        bus_wr(8'h34, ctlw(5'd1, 5'd1, 0, 0, 0, 0));
        push(2'b00, 5'd1, 5'd1, 16'h1111, 1'b1);
        bus_wr(8'h3C, 32'h0000_1111);
        bus_wr(8'h3C, 32'h0000_2222);
        bus_wr(8'h30, 32'h0000_0500);
        bus_wr(8'h38, 32'h0000_3333);
        bus_wr(8'h34, ctlw(5'd2, 5'd2, 1, 0, 1, 1));
        wait_idle();
        bus_rd(8'h3C, v); chk(v == 32'h0000_1111, "R11 address kept", v, 32'h0000_1111);
        bus_rd(8'h30, v); chk(v == 32'h0000_0100, "R11 divider kept", v, 32'h0000_0100);
        bus_rd(8'h34, v); chk(v == ctlw(5'd1, 5'd1, 0, 0, 0, 0), "R11 control kept", v, ctlw(5'd1, 5'd1, 0, 0, 0, 0));
        bus_rd(8'h38, v); chk(v == {16'h0, phy_val(5'd12, 5'd5)}, "R11 data kept", v, {16'h0, phy_val(5'd12, 5'd5)});

        // divider 3: period 2*(2*3+1) clocks of 8 ns
        bus_wr(8'h30, 32'h0000_0300);
        push(2'b00, 5'd1, 5'd1, 16'h00F0, 1'b1);
        bus_wr(8'h3C, 32'h0000_00F0);
        @(posedge mdc); t0 = $realtime;
        @(posedge mdc); t1 = $realtime;
        chk((t1 - t0) == 112.0, "R2 mdc period ns", 32'($rtoi(t1 - t0)), 32'd112);
        wait_idle();

        // scan bit: stored, no bus activity
        bus_wr(8'h34, ctlw(5'd1, 5'd1, 0, 0, 1, 0));
        bus_rd(8'h34, v); chk(v == 32'h0000_0821, "R12 scan bit readback", v, 32'h0000_0821);
        repeat (20) @(negedge clk);
        bus_rd(8'h30, v); chk(v[0] == 1'b0 && mdc == 1'b0, "R12 scan bit starts nothing", v, 32'h0000_0300);

        repeat (10) @(negedge clk);
        chk(sb_q.size() == 0 && mon_k < 0, "R4 every expected frame seen", 32'(sb_q.size()), 32'h0);
        chk(n_seen == n_push, "R11 no extra frames", 32'(n_seen), 32'(n_push));
        finish_run();
    end
endmodule